// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Selectable Line Refill

This block sits between an instruction fetch unit and a word-wide memory port of a word-addressed processor whose instructions are one word each. It keeps sixteen instruction words as four lines of four words. Each line has a valid flag and a stored tag. A fetch that finds its line present is answered in the cycle it is presented. A fetch that does not find its line spends that cycle discovering the miss. The cache then refills the complete line from memory and answers in the final refill cycle.

A parameter fixes how the refill talks to memory. In single-word mode the cache issues one read per word, in ascending word order. In burst mode it issues one request at the line base, and memory returns the four words back to back after its first-access latency. Two counters record the hits and misses served. There is no write path. Every conflicting line simply replaces the resident one.

Top module: `icache_dm`

## Requirements
- R1: After reset, ready_o is high, rvalid_o and mem_req_o are low, both counters read zero and every line is invalid, so the first fetch to any address misses.
- R2: A word address splits into word offset in bits [1:0], line index in bits [3:2] and tag in the bits above. A fetch hits only when the indexed line is valid and its stored tag equals the address tag.
- R3: A fetch is presented with req_i high while ready_o is high. On a hit, rvalid_o is high with the stored word on rdata_o in that same cycle, and ready_o stays high, so a hit costs one cycle.
- R4: On a miss, the presenting cycle is the miss-detect cycle. ready_o is low from the next cycle until the response. rvalid_o rises in the cycle the last refill word arrives, carrying the requested word, and ready_o is high again in the cycle after.
- R5: With BURST=0, the refill issues one mem_req_o pulse per word with mem_burst_o low, at line base plus 0, 1, 2, 3 in that order. Each request waits for its data. Against a memory that returns data four cycles after the request cycle, a miss costs 21 cycles from presentation to response inclusive.
- R6: With BURST=1, the refill issues a single mem_req_o pulse with mem_burst_o high at the line base (offset 0). It accepts four consecutive data beats, in ascending word order. Against a memory whose first beat comes four cycles after the request, a miss costs 9 cycles.
- R7: After a refill, all four words of the line hit and return the memory contents of their own addresses.
- R8: A miss to a valid line whose tag differs replaces the resident block. For example, address 18 evicts the block holding address 2, and a later fetch of address 2 misses again.
- R9: hit_cnt_o increments by one for each hit and miss_cnt_o by one for each miss. Neither changes while req_i is low.
- R10: The fetch stream 0..10 followed by three passes over 11..30 yields 55 hits and 16 misses, with a total fetch cost of 391 cycles in single-word mode and 199 cycles in burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Fetch request |
| addr_i | input | ADDR_W | Fetch word address |
| ready_o | output | 1 | Cache can accept a fetch |
| rvalid_o | output | 1 | Fetch response valid |
| rdata_o | output | DATA_W | Fetched instruction word |
| mem_req_o | output | 1 | Memory read request pulse |
| mem_burst_o | output | 1 | Request is a four-word burst |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_rvalid_i | input | 1 | Memory data beat valid |
| mem_rdata_i | input | DATA_W | Memory data beat |
| hit_cnt_o | output | CNT_W | Hits served |
| miss_cnt_o | output | CNT_W | Misses served |

## Verification
A hit answers combinationally in the presenting cycle. A miss answers 20 cycles later in single-word mode and 8 cycles later in burst mode. The counters move at the clock edge that ends the presenting cycle. The bench drives each fetch on a falling edge and samples a quarter period later, before the next rising edge. It counts one cycle per poll until rvalid_o is seen, so the measured cost counts the presenting cycle and the response cycle. Counter and memory-request checks are made only after the fetch has been released at a later falling edge.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_state_e;
endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int LINES = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [TAG_W-1:0] sel_tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int l = 0; l < LINES; l++) tag_q[l] <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
      tag_q[wr_idx_i]   <= wr_tag_i;
    end
  end

  // one comparator: select the indexed tag first, then compare
  assign sel_tag = tag_q[lk_idx_i];
  assign hit_o   = valid_q[lk_idx_i] && (sel_tag == lk_tag_i);
endmodule

// File: rtl/icache_data.sv
module icache_data #(
  parameter int LINES  = 4,
  parameter int WPL    = 4,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = LINES * WPL;

  logic [DATA_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) word_q[{wr_idx_i, wr_off_i}] <= wr_data_i;
  end

  assign rd_data_o = word_q[{rd_idx_i, rd_off_i}];
endmodule

// File: rtl/icache_refill.sv
module icache_refill
  import icache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  parameter int BURST  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              mem_rvalid_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_burst_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] line_addr_o,
  output logic              wr_en_o,
  output logic [OFF_W-1:0]  wr_off_o,
  output logic              done_o
);
  localparam logic [OFF_W-1:0] LastOff = '1;

  fill_state_e       st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  cnt_q;
  logic              pend_q;
  logic              pend_clr;

  assign busy_o      = (st_q == ST_FILL);
  assign mem_req_o   = busy_o && !pend_q;
  assign mem_addr_o  = {addr_q[ADDR_W-1:OFF_W], cnt_q};
  assign wr_en_o     = busy_o && pend_q && mem_rvalid_i;
  assign wr_off_o    = cnt_q;
  assign done_o      = wr_en_o && (cnt_q == LastOff);
  assign line_addr_o = addr_q;

  // burst: one request covers the line; word mode: one request per beat
  if (BURST != 0) begin : g_burst
    assign mem_burst_o = mem_req_o;
    assign pend_clr    = done_o;
  end else begin : g_word
    assign mem_burst_o = 1'b0;
    assign pend_clr    = wr_en_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (st_q == ST_IDLE) begin
      if (start_i) begin
        st_q   <= ST_FILL;
        addr_q <= miss_addr_i;
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end
    end else begin
      if (mem_req_o)     pend_q <= 1'b1;
      else if (pend_clr) pend_q <= 1'b0;
      if (wr_en_o)       cnt_q  <= cnt_q + 1'b1;
      if (done_o)        st_q   <= ST_IDLE;
    end
  end
endmodule

// File: rtl/icache_dm.sv
module icache_dm #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 4,
  parameter int BURST      = 0,
  parameter int CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_burst_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam logic [OFF_W-1:0] LastOff = '1;

  logic              busy, hit, accept, hit_acc, miss_acc;
  logic              wr_en, done;
  logic [OFF_W-1:0]  wr_off;
  logic [ADDR_W-1:0] line_addr, rd_addr;
  logic [DATA_W-1:0] rd_data;

  assign accept   = req_i && !busy;
  assign hit_acc  = accept && hit;
  assign miss_acc = accept && !hit;
  assign rd_addr  = busy ? line_addr : addr_i;

  icache_tags #(
    .LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lk_idx_i (addr_i[OFF_W +: IDX_W]),
    .lk_tag_i (addr_i[ADDR_W-1 -: TAG_W]),
    .hit_o    (hit),
    .wr_en_i  (done),
    .wr_idx_i (line_addr[OFF_W +: IDX_W]),
    .wr_tag_i (line_addr[ADDR_W-1 -: TAG_W])
  );

  icache_data #(
    .LINES(NUM_LINES), .WPL(LINE_WORDS), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) u_data (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (line_addr[OFF_W +: IDX_W]),
    .wr_off_i  (wr_off),
    .wr_data_i (mem_rdata_i),
    .rd_idx_i  (rd_addr[OFF_W +: IDX_W]),
    .rd_off_i  (rd_addr[OFF_W-1:0]),
    .rd_data_o (rd_data)
  );

  icache_refill #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BURST(BURST)
  ) u_refill (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (miss_acc),
    .miss_addr_i  (addr_i),
    .mem_rvalid_i (mem_rvalid_i),
    .busy_o       (busy),
    .mem_req_o    (mem_req_o),
    .mem_burst_o  (mem_burst_o),
    .mem_addr_o   (mem_addr_o),
    .line_addr_o  (line_addr),
    .wr_en_o      (wr_en),
    .wr_off_o     (wr_off),
    .done_o       (done)
  );

  assign ready_o  = !busy;
  assign rvalid_o = hit_acc || done;
  // last beat is still on the memory port when the response goes out
  assign rdata_o  = (done && line_addr[OFF_W-1:0] == LastOff) ? mem_rdata_i : rd_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else begin
      if (hit_acc)  hit_cnt_o  <= hit_cnt_o + 1'b1;
      if (miss_acc) miss_cnt_o <= miss_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/icache_chk.sv
module icache_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  parameter int BURST  = 0,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic              mem_req_o,
  input logic              mem_burst_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [CNT_W-1:0]  hit_cnt_o,
  input logic [CNT_W-1:0]  miss_cnt_o
);
  // R3
  hit_keeps_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && rvalid_o) |=> ready_o);
  // R4
  miss_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !rvalid_o) |=> !ready_o);
  // R4
  resume_after_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !ready_o) |=> ready_o);
  // R4
  mem_only_in_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);
  // R5
  word_mode_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && BURST == 0) |-> !mem_burst_o);
  // R6
  burst_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && BURST != 0) |-> (mem_burst_o && mem_addr_o[OFF_W-1:0] == '0));
  // R9
  hit_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && rvalid_o) |=> hit_cnt_o == $past(hit_cnt_o) + 1'b1);
  // R9
  miss_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !rvalid_o) |=> miss_cnt_o == $past(miss_cnt_o) + 1'b1);
  // R9
  idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (hit_cnt_o == $past(hit_cnt_o) && miss_cnt_o == $past(miss_cnt_o)));
endmodule

bind icache_dm icache_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BURST(BURST), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_req_o   (mem_req_o),
  .mem_burst_o (mem_burst_o),
  .mem_addr_o  (mem_addr_o),
  .hit_cnt_o   (hit_cnt_o),
  .miss_cnt_o  (miss_cnt_o)
);

// File: tb/tb_icache_dm.sv
module tb_mem_model #(
  parameter int AW  = 16,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          burst,
  input  logic [AW-1:0] addr,
  output logic          rvalid,
  output logic [31:0]   rdata,
  output int            n_req,
  output logic [AW-1:0] last_addr,
  output logic          last_burst
);
  logic          active;
  logic [2:0]    rem, beats;
  logic [AW-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; rem <= '0; beats <= '0; cur <= '0;
      n_req <= 0; last_addr <= '0; last_burst <= 1'b0;
    end else if (req) begin
      active <= 1'b1; rem <= 3'(LAT - 1); beats <= burst ? 3'd4 : 3'd1;
      cur <= addr; n_req <= n_req + 1; last_addr <= addr; last_burst <= burst;
    end else if (active && rem != 0) begin
      rem <= rem - 1'b1;
    end else if (active) begin
      if (beats == 3'd1) active <= 1'b0;
      beats <= beats - 1'b1;
      cur   <= cur + 1'b1;
    end
  end

  assign rvalid = active && rem == 0;
  assign rdata  = {cur ^ 16'h5A5A, cur};
endmodule

module tb_icache_dm;
  timeunit 1ns; timeprecision 1ps;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        req0 = 1'b0, req1 = 1'b0;
  logic [15:0] addr0 = '0, addr1 = '0;
  logic        rdy0, rdy1, rv0, rv1, mrq0, mrq1, mbs0, mbs1, mrv0, mrv1, lb0, lb1;
  logic [31:0] rd0, rd1, mrd0, mrd1;
  logic [15:0] ma0, ma1, hc0, hc1, mc0, mc1, la0, la1;
  int          nr0, nr1;
  int          checks = 0, fails = 0;

  icache_dm #(.BURST(0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req0), .addr_i(addr0), .ready_o(rdy0),
    .rvalid_o(rv0), .rdata_o(rd0), .mem_req_o(mrq0), .mem_burst_o(mbs0),
    .mem_addr_o(ma0), .mem_rvalid_i(mrv0), .mem_rdata_i(mrd0),
    .hit_cnt_o(hc0), .miss_cnt_o(mc0));
  tb_mem_model mem0 (.clk(clk), .rst_n(rst_n), .req(mrq0), .burst(mbs0), .addr(ma0),
    .rvalid(mrv0), .rdata(mrd0), .n_req(nr0), .last_addr(la0), .last_burst(lb0));

  icache_dm #(.BURST(1)) dut_bst (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req1), .addr_i(addr1), .ready_o(rdy1),
    .rvalid_o(rv1), .rdata_o(rd1), .mem_req_o(mrq1), .mem_burst_o(mbs1),
    .mem_addr_o(ma1), .mem_rvalid_i(mrv1), .mem_rdata_i(mrd1),
    .hit_cnt_o(hc1), .miss_cnt_o(mc1));
  tb_mem_model mem1 (.clk(clk), .rst_n(rst_n), .req(mrq1), .burst(mbs1), .addr(ma1),
    .rvalid(mrv1), .rdata(mrd1), .n_req(nr1), .last_addr(la1), .last_burst(lb1));

  function automatic logic [31:0] exp_word(input logic [15:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction
  function automatic int hits(input int m);   return m == 0 ? int'(hc0) : int'(hc1); endfunction
  function automatic int misses(input int m); return m == 0 ? int'(mc0) : int'(mc1); endfunction
  function automatic int nreq(input int m);   return m == 0 ? nr0 : nr1; endfunction
  function automatic int miss_cost(input int m); return m == 0 ? 21 : 9; endfunction

  task automatic check(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    req0 = 1'b0; req1 = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fetch(input int m, input logic [15:0] a, output logic [31:0] d, output int cyc);
    cyc = 0;
    d   = '0;
    @(negedge clk);
    if (m == 0) begin req0 = 1'b1; addr0 = a; end
    else        begin req1 = 1'b1; addr1 = a; end
    forever begin
      #(CLK_P/4);
      cyc++;
      if ((m == 0) ? rv0 : rv1) begin
        d = (m == 0) ? rd0 : rd1;
        break;
      end
      if (cyc > 100) break;
      @(negedge clk);
    end
    @(negedge clk);
    req0 = 1'b0; req1 = 1'b0;
  endtask

  task automatic t_reset(input int m);
    logic [31:0] d; int c;
    do_reset();
    #1;
    // R1
    check(((m == 0) ? rdy0 : rdy1) == 1'b1, "R1 ready after reset", (m == 0) ? rdy0 : rdy1, 1);
    check(((m == 0) ? rv0 : rv1) == 1'b0, "R1 no response after reset", (m == 0) ? rv0 : rv1, 0);
    check(hits(m) == 0 && misses(m) == 0, "R1 counters zero", hits(m) + misses(m), 0);
    // R9: idle cycles leave counters and memory untouched
    repeat (5) @(negedge clk);
    check(hits(m) == 0 && misses(m) == 0 && nreq(m) == 0, "R9 idle no activity",
          hits(m) + misses(m) + nreq(m), 0);
    fetch(m, 16'h0000, d, c);
    check(c == miss_cost(m), "R1 first fetch misses", c, miss_cost(m));
  endtask

  task automatic t_cold_and_line(input int m);
    logic [31:0] d; int c, n0;
    do_reset();
    n0 = nreq(m);
    fetch(m, 16'h0005, d, c);
    // R4 R5 R6
    check(c == miss_cost(m), "R4 miss cost", c, miss_cost(m));
    check(d == exp_word(16'h0005), "R4 miss data", d, exp_word(16'h0005));
    if (m == 0) begin
      check(nreq(m) - n0 == 4, "R5 one request per word", nreq(m) - n0, 4);
      check(la0 == 16'h0007 && !lb0, "R5 last request is word 3", la0, 16'h0007);
    end else begin
      check(nreq(m) - n0 == 1, "R6 single burst request", nreq(m) - n0, 1);
      check(la1 == 16'h0004 && lb1, "R6 burst at line base", la1, 16'h0004);
    end
    check(misses(m) == 1 && hits(m) == 0, "R9 one miss counted", misses(m), 1);
    // R7 R3 R2
    for (int w = 4; w < 8; w++) begin
      fetch(m, 16'(w), d, c);
      check(c == 1, "R3 hit cost", c, 1);
      check(d == exp_word(16'(w)), "R7 line word data", d, exp_word(16'(w)));
    end
    check(hits(m) == 4, "R9 hits counted", hits(m), 4);
    // R2: same index, different tag misses
    fetch(m, 16'h1004, d, c);
    check(c == miss_cost(m), "R2 tag mismatch misses", c, miss_cost(m));
    check(d == exp_word(16'h1004), "R2 refilled data", d, exp_word(16'h1004));
  endtask

  task automatic t_last_word(input int m);
    logic [31:0] d; int c;
    do_reset();
    fetch(m, 16'h0123, d, c);
    // R4: offset 3 is delivered from the final beat
    check(c == miss_cost(m), "R4 last-word miss cost", c, miss_cost(m));
    check(d == exp_word(16'h0123), "R4 last-word data", d, exp_word(16'h0123));
    fetch(m, 16'h0120, d, c);
    check(c == 1 && d == exp_word(16'h0120), "R7 word 0 after fill", d, exp_word(16'h0120));
  endtask

  task automatic t_evict(input int m);
    logic [31:0] d; int c;
    do_reset();
    fetch(m, 16'd2, d, c);
    fetch(m, 16'd18, d, c);
    // R8
    check(c == miss_cost(m) && d == exp_word(16'd18), "R8 conflict fill", c, miss_cost(m));
    fetch(m, 16'd17, d, c);
    check(c == 1 && d == exp_word(16'd17), "R8 new block resident", d, exp_word(16'd17));
    fetch(m, 16'd2, d, c);
    check(c == miss_cost(m), "R8 old block evicted", c, miss_cost(m));
    check(misses(m) == 3 && hits(m) == 1, "R9 evict counts", misses(m), 3);
  endtask

  task automatic t_stream(input int m);
    logic [31:0] d; int c, total, bad;
    do_reset();
    total = 0; bad = 0;
    for (int a = 0; a <= 10; a++) begin
      fetch(m, 16'(a), d, c); total += c;
      if (d != exp_word(16'(a))) bad++;
    end
    for (int p = 0; p < 3; p++)
      for (int a = 11; a <= 30; a++) begin
        fetch(m, 16'(a), d, c); total += c;
        if (d != exp_word(16'(a))) bad++;
      end
    // R10
    check(hits(m) == 55, "R10 stream hits", hits(m), 55);
    check(misses(m) == 16, "R10 stream misses", misses(m), 16);
    check(total == ((m == 0) ? 391 : 199), "R10 stream cycles", total, (m == 0) ? 391 : 199);
    check(bad == 0, "R10 stream data", bad, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      t_reset(m);
      t_cold_and_line(m);
      t_last_word(m);
      t_evict(m);
      t_stream(m);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule